// File: doc/BRIEF.md
# Dual-Port RAM with Selectable Output Pipelining

A synchronous two-port random-access memory. Each port (left and right) has its own clock, reset, address, write data, read/write select, a pair of chip enables of opposite polarity, an asynchronous output enable and a static mode pin. All addresses, data and controls are captured on the rising edge of the port's clock. Both ports can reach every word at the same time, including the same word.

The mode pin sets the read latency of its port. In flow-through mode, read data for an address captured at edge n is presented during the cycle that follows edge n. In pipelined mode, the data passes through one more register and appears one cycle later. In pipelined mode the output also needs two consecutive selected edges before it drives again after a deselect.

There is no tri-state bus. Each port reports whether it would drive its pins through a separate data-enable output, and its read-data output reads zero whenever that enable is low.

Top module: `dpr_dual_port`

## Requirements
- R1: A port is selected only when `ce0_*` is 0 and `ce1_*` is 1. With any other combination, an edge neither writes the array nor makes the output drive.
- R2: A selected edge with `rw_*` = 0 stores `wdata_*` at `addr_*`. Any later read of that word on either port returns the stored value.
- R3: `oe_n_*` acts with no clock. While it is 1, `rdata_en_*` is 0 and `rdata_*` is 0. Whenever `rdata_en_*` is 0, `rdata_*` is 0.
- R4: In flow-through mode, the cycle after a selected write edge has `rdata_en_*` = 0.
- R5: In flow-through mode (`pipe_*` = 0), a selected edge with `rw_*` = 1 and `oe_n_*` = 0 presents the word at that address, with `rdata_en_*` = 1, in the cycle that follows that edge.
- R6: In pipelined mode (`pipe_*` = 1), the word read at edge n is presented in the cycle after edge n+1.
- R7: In both modes, a deselected edge forces `rdata_en_*` to 0 in the cycle that follows it.
- R8: In pipelined mode, the output drives after edge n+1 only if edge n was a selected read and edge n+1 was also selected.
- R9: The ports work at the same time on any addresses. A read captured at the same edge as the other port's write to that word returns the old value. A read captured at a later edge returns the new value.
- R10: While reset is active, and until the synchronised release has completed, `rdata_en_*` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_l | input | 1 | Left port clock |
| rst_l_n | input | 1 | Left port reset, active low, asynchronous assert |
| ce0_l | input | 1 | Left chip enable, active low |
| ce1_l | input | 1 | Left chip enable, active high |
| rw_l | input | 1 | Left read (1) / write (0) select |
| oe_n_l | input | 1 | Left output enable, active low, unclocked |
| pipe_l | input | 1 | Left mode: 0 flow-through, 1 pipelined |
| addr_l | input | ADDR_W | Left word address |
| wdata_l | input | DATA_W | Left write data |
| rdata_l | output | DATA_W | Left read data, zero while not driven |
| rdata_en_l | output | 1 | Left output-drive flag |
| clk_r | input | 1 | Right port clock |
| rst_r_n | input | 1 | Right port reset, active low, asynchronous assert |
| ce0_r | input | 1 | Right chip enable, active low |
| ce1_r | input | 1 | Right chip enable, active high |
| rw_r | input | 1 | Right read (1) / write (0) select |
| oe_n_r | input | 1 | Right output enable, active low, unclocked |
| pipe_r | input | 1 | Right mode: 0 flow-through, 1 pipelined |
| addr_r | input | ADDR_W | Right word address |
| wdata_r | input | DATA_W | Right write data |
| rdata_r | output | DATA_W | Right read data, zero while not driven |
| rdata_en_r | output | 1 | Right output-drive flag |

## Verification
On every cycle, the assertions check how the drive flag follows the controls of earlier edges: a flow-through read drives, a write or a deselect releases the output, and a pipelined drive needs a read followed by a selected edge. Only the bench's scenarios can show the data itself. That covers values written and read back on each port, the one-cycle shift of pipelined data, the old and new data seen across ports at the same edge and at a later edge, writes that a deselected port ignores, and the immediate effect of the output enable between edges.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
  localparam int unsigned NUM_PORTS = 2;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } port_op_e;

  function automatic port_op_e decode_op(input logic ce_lo, input logic ce_hi,
                                         input logic rd_not_wr);
    if (ce_lo || !ce_hi) return OP_NONE;
    return rd_not_wr ? OP_READ : OP_WRITE;
  endfunction
endpackage

// File: rtl/dpr_store_bank.sv
module dpr_store_bank #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 9
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] look_addr_0,
  input  logic [ADDR_W-1:0] look_addr_1,
  output logic [DATA_W-1:0] look_data_0,
  output logic [DATA_W-1:0] look_data_1
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) cells[wr_addr] <= wr_data;
  end

  assign look_data_0 = cells[look_addr_0];
  assign look_data_1 = cells[look_addr_1];
endmodule

// File: rtl/dpr_port_ctrl.sv
module dpr_port_ctrl
  import dpr_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce0,
  input  logic              ce1,
  input  logic              rw,
  input  logic              oe_n,
  input  logic              pipe,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] word_full,
  input  logic [DATA_W-1:0] word_partner,
  output logic              st_we,
  output logic [ADDR_W-1:0] st_addr,
  output logic [DATA_W-1:0] st_wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_en
);
  localparam int unsigned SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_sync;
  logic                   run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[SYNC_STAGES-2:0], 1'b1};
  end
  assign run = rst_sync[SYNC_STAGES-1];

  port_op_e op;
  logic     sel, rd_req, wr_req;

  assign op     = decode_op(ce0, ce1, rw);
  assign sel    = (op != OP_NONE);
  assign rd_req = (op == OP_READ);
  assign wr_req = (op == OP_WRITE);

  assign st_we    = wr_req & run;
  assign st_addr  = addr;
  assign st_wdata = wdata ^ word_partner;

  logic              ft_act_q, ft_act_d, ft_ld;
  logic [DATA_W-1:0] ft_data_q;
  logic              pp_act_q, pp_act_d, pp_ld;
  logic [DATA_W-1:0] pp_data_q;

  always_comb begin
    ft_act_d = rd_req;
    ft_ld    = rd_req;
    pp_act_d = ft_act_q & sel;
    pp_ld    = ft_act_q;
  end

  always_ff @(posedge clk or negedge run) begin
    if (!run) begin
      ft_act_q  <= 1'b0;
      ft_data_q <= '0;
      pp_act_q  <= 1'b0;
      pp_data_q <= '0;
    end else begin
      ft_act_q <= ft_act_d;
      pp_act_q <= pp_act_d;
      if (ft_ld) ft_data_q <= word_full;
      if (pp_ld) pp_data_q <= ft_data_q;
    end
  end

  logic              act_sel;
  logic [DATA_W-1:0] data_sel;

  always_comb begin
    act_sel  = pipe ? pp_act_q  : ft_act_q;
    data_sel = pipe ? pp_data_q : ft_data_q;
    rdata_en = act_sel & ~oe_n;
    rdata    = rdata_en ? data_sel : '0;
  end

  AST_FT_READ_DRIVES: assert property (@(posedge clk) disable iff (!run)
    (!pipe && rd_req && !oe_n) |=> (rdata_en || pipe || oe_n)); // R5

  AST_FT_WRITE_RELEASES: assert property (@(posedge clk) disable iff (!run)
    (!pipe && wr_req) |=> (!rdata_en || pipe)); // R4

  AST_DESEL_RELEASES: assert property (@(posedge clk) disable iff (!run)
    (!sel) |=> (!rdata_en)); // R7

  AST_PIPE_TWO_SELECTS: assert property (@(posedge clk) disable iff (!run)
    (pipe && rdata_en) |-> ($past(sel) && $past(rd_req, 2))); // R8

  AST_IDLE_DATA_ZERO: assert property (@(posedge clk) disable iff (!run)
    (!rdata_en) |-> (rdata == '0)); // R3
endmodule

// File: rtl/dpr_dual_port.sv
module dpr_dual_port
  import dpr_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 9
) (
  input  logic              clk_l,
  input  logic              rst_l_n,
  input  logic              ce0_l,
  input  logic              ce1_l,
  input  logic              rw_l,
  input  logic              oe_n_l,
  input  logic              pipe_l,
  input  logic [ADDR_W-1:0] addr_l,
  input  logic [DATA_W-1:0] wdata_l,
  output logic [DATA_W-1:0] rdata_l,
  output logic              rdata_en_l,
  input  logic              clk_r,
  input  logic              rst_r_n,
  input  logic              ce0_r,
  input  logic              ce1_r,
  input  logic              rw_r,
  input  logic              oe_n_r,
  input  logic              pipe_r,
  input  logic [ADDR_W-1:0] addr_r,
  input  logic [DATA_W-1:0] wdata_r,
  output logic [DATA_W-1:0] rdata_r,
  output logic              rdata_en_r
);
  logic              clk_v   [NUM_PORTS];
  logic              rstn_v  [NUM_PORTS];
  logic              ce0_v   [NUM_PORTS];
  logic              ce1_v   [NUM_PORTS];
  logic              rw_v    [NUM_PORTS];
  logic              oen_v   [NUM_PORTS];
  logic              pipe_v  [NUM_PORTS];
  logic [ADDR_W-1:0] addr_v  [NUM_PORTS];
  logic [DATA_W-1:0] wdata_v [NUM_PORTS];
  logic [DATA_W-1:0] rdata_v [NUM_PORTS];
  logic              ren_v   [NUM_PORTS];

  assign clk_v   = '{clk_l,   clk_r};
  assign rstn_v  = '{rst_l_n, rst_r_n};
  assign ce0_v   = '{ce0_l,   ce0_r};
  assign ce1_v   = '{ce1_l,   ce1_r};
  assign rw_v    = '{rw_l,    rw_r};
  assign oen_v   = '{oe_n_l,  oe_n_r};
  assign pipe_v  = '{pipe_l,  pipe_r};
  assign addr_v  = '{addr_l,  addr_r};
  assign wdata_v = '{wdata_l, wdata_r};

  assign rdata_l    = rdata_v[0];
  assign rdata_en_l = ren_v[0];
  assign rdata_r    = rdata_v[1];
  assign rdata_en_r = ren_v[1];

  // look[bank][port]: content of a bank at the address of a port
  logic [DATA_W-1:0] look     [NUM_PORTS][NUM_PORTS];
  logic              st_we    [NUM_PORTS];
  logic [ADDR_W-1:0] st_addr  [NUM_PORTS];
  logic [DATA_W-1:0] st_wdata [NUM_PORTS];

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    localparam int unsigned OTHER = NUM_PORTS - 1 - p;

    logic [DATA_W-1:0] word_full;
    assign word_full = look[0][p] ^ look[1][p];

    dpr_store_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank (
      .clk         (clk_v[p]),
      .wr_en       (st_we[p]),
      .wr_addr     (st_addr[p]),
      .wr_data     (st_wdata[p]),
      .look_addr_0 (addr_v[0]),
      .look_addr_1 (addr_v[1]),
      .look_data_0 (look[p][0]),
      .look_data_1 (look[p][1])
    );

    dpr_port_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
      .clk          (clk_v[p]),
      .rst_n        (rstn_v[p]),
      .ce0          (ce0_v[p]),
      .ce1          (ce1_v[p]),
      .rw           (rw_v[p]),
      .oe_n         (oen_v[p]),
      .pipe         (pipe_v[p]),
      .addr         (addr_v[p]),
      .wdata        (wdata_v[p]),
      .word_full    (word_full),
      .word_partner (look[OTHER][p]),
      .st_we        (st_we[p]),
      .st_addr      (st_addr[p]),
      .st_wdata     (st_wdata[p]),
      .rdata        (rdata_v[p]),
      .rdata_en     (ren_v[p])
    );
  end
endmodule

// File: tb/dpr_dual_port_bench.sv
module dpr_dual_port_bench;
  localparam int unsigned AW = 8;
  localparam int unsigned DW = 9;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n;
  logic          l_ce0, l_ce1, l_rw, l_oen, l_pipe;
  logic [AW-1:0] l_addr;
  logic [DW-1:0] l_wd;
  logic [DW-1:0] l_rd;
  logic          l_en;
  logic          r_ce0, r_ce1, r_rw, r_oen, r_pipe;
  logic [AW-1:0] r_addr;
  logic [DW-1:0] r_wd;
  logic [DW-1:0] r_rd;
  logic          r_en;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  dpr_dual_port #(.ADDR_W(AW), .DATA_W(DW)) u_dpr_dual_port (
    .clk_l(clk), .rst_l_n(rst_n), .ce0_l(l_ce0), .ce1_l(l_ce1), .rw_l(l_rw),
    .oe_n_l(l_oen), .pipe_l(l_pipe), .addr_l(l_addr), .wdata_l(l_wd),
    .rdata_l(l_rd), .rdata_en_l(l_en),
    .clk_r(clk), .rst_r_n(rst_n), .ce0_r(r_ce0), .ce1_r(r_ce1), .rw_r(r_rw),
    .oe_n_r(r_oen), .pipe_r(r_pipe), .addr_r(r_addr), .wdata_r(r_wd),
    .rdata_r(r_rd), .rdata_en_r(r_en)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic en, input logic [DW-1:0] d,
                     input logic exp_en, input logic [DW-1:0] exp_d);
    logic [DW-1:0] want;
    want = exp_en ? exp_d : '0;
    n_chk++;
    if (en !== exp_en || d !== want) begin
      n_bad++;
      $display("FAIL %s: got en=%b data=%h, expected en=%b data=%h",
               req, en, d, exp_en, want);
    end
  endtask

  // op: 0 idle, 1 read, 2 write, 3 deselect through ce1 low
  task automatic drv_l(input int op, input logic [AW-1:0] a, input logic [DW-1:0] d);
    l_ce0 = (op == 0); l_ce1 = (op != 3); l_rw = (op == 1); l_addr = a; l_wd = d;
  endtask
  task automatic drv_r(input int op, input logic [AW-1:0] a, input logic [DW-1:0] d);
    r_ce0 = (op == 0); r_ce1 = (op != 3); r_rw = (op == 1); r_addr = a; r_wd = d;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    drv_l(0, '0, '0); drv_r(0, '0, '0);
    l_oen = 1'b0; r_oen = 1'b0; l_pipe = 1'b0; r_pipe = 1'b0;
    repeat (3) tick();
    drv_l(1, 8'd0, '0);
    tick();
    chk("R10 reset left", l_en, l_rd, 1'b0, '0);
    chk("R10 reset right", r_en, r_rd, 1'b0, '0);
    drv_l(0, '0, '0);
    rst_n = 1'b1;
    repeat (4) tick();
  endtask

  task automatic t_flow();
    drv_l(2, 8'd5, 9'h1A5); tick();
    chk("R4 write releases output", l_en, l_rd, 1'b0, '0);
    drv_l(2, 8'd6, 9'h0F3); tick();
    drv_l(1, 8'd5, '0); tick();
    chk("R2 R5 read addr 5", l_en, l_rd, 1'b1, 9'h1A5);
    drv_l(1, 8'd6, '0); tick();
    chk("R5 read addr 6", l_en, l_rd, 1'b1, 9'h0F3);
    drv_l(1, 8'd5, '0); drv_r(1, 8'd5, '0); tick();
    chk("R9 both read addr 5 left", l_en, l_rd, 1'b1, 9'h1A5);
    chk("R9 both read addr 5 right", r_en, r_rd, 1'b1, 9'h1A5);
    drv_l(0, '0, '0); drv_r(0, '0, '0); tick();
  endtask

  task automatic t_oe();
    drv_l(1, 8'd6, '0); tick();
    chk("R3 driven with oe low", l_en, l_rd, 1'b1, 9'h0F3);
    l_oen = 1'b1; #1;
    chk("R3 oe high releases at once", l_en, l_rd, 1'b0, '0);
    l_oen = 1'b0; #1;
    chk("R3 oe low drives again", l_en, l_rd, 1'b1, 9'h0F3);
    drv_l(0, '0, '0); tick();
  endtask

  task automatic t_desel();
    drv_l(1, 8'd5, '0); tick();
    chk("R5 read before deselect", l_en, l_rd, 1'b1, 9'h1A5);
    drv_l(0, 8'd5, '0); tick();
    chk("R7 R1 ce0 high releases", l_en, l_rd, 1'b0, '0);
    drv_l(1, 8'd5, '0); tick();
    drv_l(3, 8'd5, '0); l_rw = 1'b1; tick();
    chk("R1 ce1 low releases", l_en, l_rd, 1'b0, '0);
    drv_l(3, 8'd5, 9'h000); tick();
    drv_l(0, 8'd5, 9'h000); l_rw = 1'b0; tick();
    drv_l(1, 8'd5, '0); tick();
    chk("R1 deselected write ignored", l_en, l_rd, 1'b1, 9'h1A5);
    drv_l(0, '0, '0); tick(); tick();
  endtask

  task automatic t_pipe();
    l_pipe = 1'b1; tick();
    drv_l(1, 8'd6, '0); tick();
    chk("R6 no data one cycle after first read", l_en, l_rd, 1'b0, '0);
    drv_l(1, 8'd5, '0); tick();
    chk("R6 addr 6 one cycle late", l_en, l_rd, 1'b1, 9'h0F3);
    drv_l(1, 8'd5, '0); tick();
    chk("R6 addr 5 one cycle late", l_en, l_rd, 1'b1, 9'h1A5);
    drv_l(0, '0, '0); tick();
    chk("R7 pipelined deselect releases", l_en, l_rd, 1'b0, '0);
    tick();
  endtask

  task automatic t_pipe_react();
    drv_l(1, 8'd6, '0); tick();
    drv_l(0, 8'd6, '0); tick();
    chk("R8 read then deselect stays released", l_en, l_rd, 1'b0, '0);
    tick();
    chk("R8 still released", l_en, l_rd, 1'b0, '0);
    drv_l(1, 8'd6, '0); tick();
    chk("R8 one selected edge not enough", l_en, l_rd, 1'b0, '0);
    drv_l(1, 8'd5, '0); tick();
    chk("R8 two selected edges drive", l_en, l_rd, 1'b1, 9'h0F3);
    drv_l(0, '0, '0); tick(); tick();
    l_pipe = 1'b0; tick();
  endtask

  task automatic t_cross();
    drv_r(2, 8'd9, 9'h0AA); tick();
    drv_l(2, 8'd9, 9'h155); drv_r(1, 8'd9, '0); tick();
    chk("R9 same-edge read sees old", r_en, r_rd, 1'b1, 9'h0AA);
    drv_l(0, '0, '0); drv_r(1, 8'd9, '0); tick();
    chk("R9 later read sees new", r_en, r_rd, 1'b1, 9'h155);
    drv_r(2, 8'd9, 9'h1FE); drv_l(1, 8'd9, '0); tick();
    chk("R9 left same-edge read sees old", l_en, l_rd, 1'b1, 9'h155);
    drv_r(0, '0, '0); drv_l(1, 8'd9, '0); tick();
    chk("R9 left later read sees new", l_en, l_rd, 1'b1, 9'h1FE);
    drv_l(2, 8'd10, 9'h012); drv_r(2, 8'd11, 9'h034); tick();
    drv_l(1, 8'd11, '0); drv_r(1, 8'd10, '0); tick();
    chk("R2 R9 left reads right's write", l_en, l_rd, 1'b1, 9'h034);
    chk("R2 R9 right reads left's write", r_en, r_rd, 1'b1, 9'h012);
    drv_l(0, '0, '0); drv_r(0, '0, '0); tick();
  endtask

  initial begin
    t_reset();
    t_flow();
    t_oe();
    t_desel();
    t_pipe();
    t_pipe_react();
    t_cross();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got no end, expected end within 5000 cycles");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule